// File: doc/BRIEF.md
# Size-Selectable ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a register machine with two operands, in which the result overwrites the second operand. It receives a first operand (`src1_i`) and a second operand (`src2_i`), a 3-bit operation select, a 2-bit operand size and the current extend flag. From these it produces the new destination value and a five-bit condition code vector.

The operation runs only on the low 8, 16 or 32 bits that the size selects. The flags are computed from those same low bits. When the size is byte or word, the destination bits above the selected width pass through unchanged from the second operand. A register file can therefore write the whole 32-bit output back without a separate merge step. Subtraction takes the first operand away from the second.

Top module: `szalu`

## Requirements
- R1: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 both select all 32 bits.
- R2: Op code 0 (add) writes the sum of the sized operands, src2 + src1, modulo the selected width.
- R3: Op code 1 (subtract) writes src2 minus src1, modulo the selected width.
- R4: Op codes 2, 3 and 4 write the bitwise AND, OR and exclusive-OR of the sized operands.
- R5: Op code 5 (invert) writes the complement of the sized src2 and ignores src1 entirely.
- R6: Result bits above the selected width are equal to the same bits of src2.
- R7: `ccr_o` is ordered {X,N,Z,V,C} from bit 4 down to bit 0. N is the top bit of the sized result. Z is 1 exactly when every bit of the sized result is 0, whatever the upper bits hold.
- R8: For add and subtract, C is the carry out of the sized top bit (for subtract, the borrow, set when src1 > src2 unsigned), and X equals C.
- R9: For add and subtract, V is 1 exactly when the signed result at the selected width falls outside the signed range of that width.
- R10: For op codes 2 to 7, V and C are 0 and X equals `x_i`.
- R11: Op codes 6 and 7 pass src2 through unchanged, with N and Z taken from its sized value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select (0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 invert, 6/7 pass) |
| size_i | input | 2 | Operand width select (0 byte, 1 word, 2/3 long) |
| src1_i | input | 32 | First operand |
| src2_i | input | 32 | Second operand, which is also the destination's previous value |
| x_i | input | 1 | Current extend flag |
| result_o | output | 32 | New destination value, merged to partial width |
| ccr_o | output | 5 | Updated condition codes {X,N,Z,V,C} |

## Verification
Several flags can change in the same evaluation, and width merging can coincide with flag generation. A byte add of 0x80 and 0x80 sets carry, overflow and zero together. A sized result of zero placed under non-zero upper bits of src2 must still set Z. The bench aims these collisions on purpose: it places operands exactly at the sign and carry edges of each width, and it fills src2's upper bits with noise. It then compares the full 32-bit result and all five flags against a model that works on wide signed and unsigned integers rather than on carry chains.

// File: rtl/szalu_pkg.sv
package szalu_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_SIZES = 3;
  localparam int OP_W      = 3;
  localparam int SIZE_W    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_NOT = 3'd5, OP_PS6 = 3'd6, OP_PS7 = 3'd7
  } op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // lane width for size index k
  function automatic int lane_w(input int k);
    return 8 << k;
  endfunction

  // carry and signed overflow of one lane: returns {carry, ovf}
  function automatic logic [1:0] lane_cv(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b,
                                         input logic cin, input int w);
    logic [DATA_W:0] s;
    logic [DATA_W-1:0] m;
    m = (w >= DATA_W) ? '1 : ((DATA_W'(1) << w) - DATA_W'(1));
    s = {1'b0, a & m} + {1'b0, b & m} + {{DATA_W{1'b0}}, cin};
    return {s[w], (a[w-1] == b[w-1]) && (s[w-1] != a[w-1])};
  endfunction
endpackage

// File: rtl/szalu_mask.sv
module szalu_mask
  import szalu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NUM_SIZES
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [NS-1:0]     sel_o,
  output logic [DW-1:0]     mask_o
);
  logic [NS-1:0][DW-1:0] lane_mask;

  for (genvar k = 0; k < NS; k++) begin : g_lane
    localparam int W = 8 << k;
    if (k == NS - 1) begin : g_top
      assign sel_o[k] = (size_i >= SIZE_W'(k));
    end else begin : g_low
      assign sel_o[k] = (size_i == SIZE_W'(k));
    end
    assign lane_mask[k] = sel_o[k] ? DW'((64'd1 << W) - 64'd1) : '0;
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < NS; k++) mask_o = mask_o | lane_mask[k];
  end
endmodule

// File: rtl/szalu_arith.sv
module szalu_arith
  import szalu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NUM_SIZES
) (
  input  logic [DW-1:0] src1_i,
  input  logic [DW-1:0] src2_i,
  input  logic          sub_i,
  input  logic [NS-1:0] sel_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o,
  output logic          ovf_o
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   full;
  logic [NS-1:0] cvec;
  logic [NS-1:0] vvec;

  assign b_eff = sub_i ? ~src1_i : src1_i;
  assign full  = {1'b0, src2_i} + {1'b0, b_eff} + {{DW{1'b0}}, sub_i};
  assign sum_o = full[DW-1:0];

  for (genvar k = 0; k < NS; k++) begin : g_cv
    localparam int W = 8 << k;
    logic [1:0] cv;
    assign cv      = lane_cv(src2_i, b_eff, sub_i, W);
    assign cvec[k] = cv[1] ^ sub_i;   // borrow is inverted carry
    assign vvec[k] = cv[0];
  end

  assign carry_o = |(cvec & sel_i);
  assign ovf_o   = |(vvec & sel_i);
endmodule

// File: rtl/szalu_logic.sv
module szalu_logic
  import szalu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   src1_i,
  input  logic [DW-1:0]   src2_i,
  output logic [DW-1:0]   res_o
);
  always_comb begin
    unique case (op_e'(op_i))
      OP_AND:  res_o = src1_i & src2_i;
      OP_OR:   res_o = src1_i | src2_i;
      OP_XOR:  res_o = src1_i ^ src2_i;
      OP_NOT:  res_o = ~src2_i;
      default: res_o = src2_i;
    endcase
  end
endmodule

// File: rtl/szalu_flags.sv
module szalu_flags
  import szalu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NUM_SIZES
) (
  input  logic [DW-1:0] res_m_i,
  input  logic [NS-1:0] sel_i,
  input  logic          arith_i,
  input  logic          carry_i,
  input  logic          ovf_i,
  input  logic          x_i,
  output ccr_t          ccr_o
);
  logic [NS-1:0] msbvec;

  for (genvar k = 0; k < NS; k++) begin : g_msb
    localparam int W = 8 << k;
    assign msbvec[k] = res_m_i[W-1];
  end

  always_comb begin
    ccr_o.n = |(msbvec & sel_i);
    ccr_o.z = (res_m_i == '0);
    ccr_o.c = arith_i & carry_i;
    ccr_o.v = arith_i & ovf_i;
    ccr_o.x = arith_i ? carry_i : x_i;
  end
endmodule

// File: rtl/szalu.sv
module szalu
  import szalu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NS = NUM_SIZES
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DW-1:0]     src1_i,
  input  logic [DW-1:0]     src2_i,
  input  logic              x_i,
  output logic [DW-1:0]     result_o,
  output logic [4:0]        ccr_o
);
  logic [NS-1:0] sel;
  logic [DW-1:0] mask;
  logic [DW-1:0] sum;
  logic [DW-1:0] logic_res;
  logic [DW-1:0] raw_res;
  logic [DW-1:0] res_masked;
  logic          carry_out;
  logic          ovf_out;
  logic          is_arith;
  ccr_t          ccr;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

  szalu_mask  #(.DW(DW), .NS(NS)) u_mask (
    .size_i(size_i), .sel_o(sel), .mask_o(mask));

  szalu_arith #(.DW(DW), .NS(NS)) u_arith (
    .src1_i(src1_i), .src2_i(src2_i), .sub_i(op_i == OP_SUB),
    .sel_i(sel), .sum_o(sum), .carry_o(carry_out), .ovf_o(ovf_out));

  szalu_logic #(.DW(DW)) u_logic (
    .op_i(op_i), .src1_i(src1_i), .src2_i(src2_i), .res_o(logic_res));

  assign raw_res    = is_arith ? sum : logic_res;
  assign res_masked = raw_res & mask;

  szalu_flags #(.DW(DW), .NS(NS)) u_flags (
    .res_m_i(res_masked), .sel_i(sel), .arith_i(is_arith),
    .carry_i(carry_out), .ovf_i(ovf_out), .x_i(x_i), .ccr_o(ccr));

  assign result_o = res_masked | (src2_i & ~mask);
  assign ccr_o    = ccr;
endmodule

// File: rtl/szalu_chk.sv
module szalu_chk (
  input logic [2:0]  op_i,
  input logic [1:0]  size_i,
  input logic [31:0] src2_i,
  input logic        x_i,
  input logic [31:0] result_o,
  input logic [4:0]  ccr_o,
  input logic        carry_out,
  input logic        ovf_out
);
  logic [31:0] m;
  logic [31:0] rs;
  logic        arith;

  always_comb begin
    m     = (size_i == 2'd0) ? 32'h0000_00FF :
            (size_i == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    rs    = result_o & m;
    arith = (op_i < 3'd2);
  end

  always_comb begin
    assert_upper_kept_R6: assert final (((result_o ^ src2_i) & ~m) == 32'h0);
    assert_zero_flag_R7: assert final (ccr_o[2] == (rs == 32'h0));
    assert_ext_tracks_carry_R8: assert final (!arith || (ccr_o[4] == ccr_o[0]));
    assert_carry_from_lane_R8: assert final (!arith || (ccr_o[0] == carry_out));
    assert_no_overflow_R9: assert final (!arith || (ccr_o[1] == ovf_out));
    assert_logic_flags_R10: assert final (arith ||
        (ccr_o[1:0] == 2'b00 && ccr_o[4] == x_i));
    assert_invert_R5: assert final ((op_i != 3'd5) || (rs == (~src2_i & m)));
  end
endmodule

bind szalu szalu_chk u_chk (
  .op_i(op_i), .size_i(size_i), .src2_i(src2_i), .x_i(x_i),
  .result_o(result_o), .ccr_o(ccr_o),
  .carry_out(carry_out), .ovf_out(ovf_out));

// File: tb/szalu_tb.sv
module szalu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] s1, s2;
  logic        xin;
  logic [31:0] result;
  logic [4:0]  ccr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [36:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  szalu u_dut (.op_i(op), .size_i(size), .src1_i(s1), .src2_i(s2),
               .x_i(xin), .result_o(result), .ccr_o(ccr));

  // independent model: wide integers, returns {result, X,N,Z,V,C}
  function automatic logic [36:0] model(input logic [2:0] o, input logic [1:0] sz,
                                        input logic [31:0] a32, input logic [31:0] b32,
                                        input logic xi);
    int w;
    longint unsigned m, a, b, r;
    longint sa, sb, sr, lim;
    logic c, v, xo, n, z;
    logic [31:0] full;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m   = (longint'(1) << w) - 1;
    lim = longint'(1) << (w - 1);
    a   = longint'(a32) & m;
    b   = longint'(b32) & m;
    sa  = (a >= longint'(lim)) ? longint'(a) - longint'(m) - 1 : longint'(a);
    sb  = (b >= longint'(lim)) ? longint'(b) - longint'(m) - 1 : longint'(b);
    c = 1'b0; v = 1'b0; xo = xi;
    case (o)
      3'd0: begin r = (a + b) & m; c = ((a + b) >> w) != 0; sr = sb + sa;
                  v = (sr >= lim) || (sr < -lim); xo = c; end
      3'd1: begin r = (b - a) & m; c = a > b; sr = sb - sa;
                  v = (sr >= lim) || (sr < -lim); xo = c; end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: r = ~b & m;
      default: r = b;
    endcase
    n = ((r >> (w - 1)) & 1) != 0;
    z = (r == 0);
    full = (b32 & ~32'(m)) | 32'(r);
    return {full, xo, n, z, v, c};
  endfunction

  task automatic drive(input logic [2:0] o, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic xi, input string tag);
    @(negedge clk);
    op = o; size = sz; s1 = a; s2 = b; xin = xi;
    exp_q.push_back(model(o, sz, a, b, xi));
    tag_q.push_back(tag);
  endtask

  task automatic expect_direct(input logic [36:0] e, input string tag);
    // compare model with a hand-computed value (guards the model itself)
    logic [36:0] m;
    m = model(op, size, s1, s2, xin);
    tests++;
    if (m !== e) begin
      fails++;
      $display("FAIL %s model=%h expected=%h", tag, m, e);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [36:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if ({result, ccr} !== e) begin
        fails++;
        $display("FAIL %s actual res=%h ccr=%b expected res=%h ccr=%b",
                 t, result, ccr, e[36:5], e[4:0]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    op = 3'd0; size = 2'd0; s1 = '0; s2 = '0; xin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset/idle state: zero inputs add -> zero result, Z only (R7)
    tests++;
    if (result !== 32'h0 || ccr !== 5'b00100) begin
      fails++;
      $display("FAIL R7 reset actual res=%h ccr=%b expected res=0 ccr=00100", result, ccr);
    end
    rst = 1'b0;

    // R4 / R2 byte examples
    drive(3'd2, 2'd0, 32'h1D, 32'h0E, 1'b0, "R4 and byte");
    expect_direct({32'h0C, 5'b00000}, "R4 model and");
    drive(3'd3, 2'd0, 32'h1D, 32'h0E, 1'b0, "R4 or byte");
    expect_direct({32'h1F, 5'b00000}, "R4 model or");
    drive(3'd0, 2'd0, 32'h1D, 32'h0E, 1'b0, "R2 add byte");
    expect_direct({32'h2B, 5'b00000}, "R2 model add");
    drive(3'd4, 2'd1, 32'h0000_F0F0, 32'h0000_FF00, 1'b0, "R4 xor word");
    // R6 upper bits of src2 kept
    drive(3'd0, 2'd0, 32'hFFFF_FF1D, 32'hAABB_CC0E, 1'b0, "R6 add byte merge");
    expect_direct({32'hAABB_CC2B, 5'b00000}, "R6 model merge");
    // R8 word carry wrap to zero under noisy upper bits, R7 Z
    drive(3'd0, 2'd1, 32'h0000_0001, 32'h5A5A_FFFF, 1'b0, "R8 word carry");
    expect_direct({32'h5A5A_0000, 5'b10101}, "R8 model carry");
    // R9 byte overflow
    drive(3'd0, 2'd0, 32'h01, 32'h7F, 1'b0, "R9 byte ovf");
    expect_direct({32'h80, 5'b01010}, "R9 model ovf");
    // carry + overflow + zero together
    drive(3'd0, 2'd0, 32'h80, 32'h1234_5680, 1'b0, "R9 R8 triple");
    expect_direct({32'h1234_5600, 5'b10111}, "R9 model triple");
    // R3 subtract ordering
    drive(3'd1, 2'd2, 32'd3, 32'd5, 1'b1, "R3 sub long");
    expect_direct({32'd2, 5'b00000}, "R3 model sub");
    drive(3'd1, 2'd2, 32'd5, 32'd3, 1'b0, "R3 sub borrow");
    expect_direct({32'hFFFF_FFFE, 5'b11001}, "R3 model borrow");
    drive(3'd1, 2'd0, 32'h01, 32'h80, 1'b0, "R9 sub byte ovf");
    expect_direct({32'h7F, 5'b00010}, "R9 model sub ovf");
    // R5 invert ignores src1; R10 X kept
    drive(3'd5, 2'd1, 32'hDEAD_BEEF, 32'h1234_0F0F, 1'b1, "R5 invert word");
    expect_direct({32'h1234_F0F0, 5'b11000}, "R5 model invert");
    drive(3'd2, 2'd2, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, "R10 logic flags");
    // R1 size 3 acts as long
    drive(3'd0, 2'd3, 32'h0001_0000, 32'hFFFF_0000, 1'b0, "R1 size3 long");
    expect_direct({32'h0000_0000, 5'b10101}, "R1 model size3");
    // R11 pass codes
    drive(3'd6, 2'd0, 32'hFFFF_FFFF, 32'h0000_0100, 1'b1, "R11 pass6 zero");
    expect_direct({32'h0000_0100, 5'b10100}, "R11 model pass");
    drive(3'd7, 2'd1, 32'h0, 32'h0000_8001, 1'b0, "R11 pass7");

    // sweep of patterns over all ops and sizes
    lf = 32'hACE1_1234;
    for (int i = 0; i < 256; i++) begin
      logic [31:0] a, b;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a = lf;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      b = (i % 4 == 0) ? (lf & 32'hFFFF_FF80) | 32'h7F : lf;
      drive(3'(i % 8), 2'(i / 8), a, b, lf[0], "R1 R2 R3 R4 R9 sweep");
    end

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule